// File: doc/BRIEF.md
# Second-Derivative Pulse Onset Detector

This block watches a stream of signed pressure samples, one per clock when `valid_i` is high, and marks the sample positions where a new pulse begins. It first inverts each sample. It then differentiates the stream twice with the same gradient operator and compares the result against a threshold supplied on `thresh_i`. A rising crossing of that threshold is a candidate onset. A candidate is confirmed only if the next candidate in the same record comes more than a minimum spacing later.

The stream is split into records, and `last_i` marks the final sample of each record. Every record yields one derivative value per input sample on the `deriv_*` outputs, for downstream use. Confirmed onsets come out on `onset_idx_o` as zero-based sample indices within the record. Confirmation needs the following candidate, so an onset is reported when that next candidate arrives. The last candidate of a record is dropped. The threshold itself (ten times the median absolute second derivative) is computed outside the block.

Top module: `pulse_onset_detector`

## Requirements
- R1: Each input sample x is replaced by its two's-complement negation p = -x before any differentiation. A positive spike in x and a negative spike in x therefore give mirrored derivative streams.
- R2: The gradient g of a record a[0..N-1] is defined as follows. g[0] = a[1]-a[0]. g[N-1] = a[N-1]-a[N-2]. Every interior point is g[i] = (a[i+1]-a[i-1]) arithmetically shifted right by one, which rounds toward minus infinity. The derivative output f equals the gradient applied twice to p. It is emitted in index order, one value per input sample.
- R3: A record has at least 2 samples and is followed by at least one idle cycle. It produces exactly N derivative outputs. `deriv_last_o` is high only with the last of them. That last value is visible after the third rising edge following the edge that captured the record's final sample.
- R4: Index i is a candidate when f[i] < T and f[i+1] > T, both strict, where T is `thresh_i`. A value equal to T never forms a crossing.
- R5: A candidate at index a is confirmed when the next candidate b of the same record satisfies b - a > MIN_GAP (default 50 samples). A spacing of exactly MIN_GAP is rejected. The confirmed index a appears on `onset_idx_o` with `onset_valid_o` high for one cycle, one edge after `deriv_o` carries f[b+1].
- R6: The final candidate of a record is never reported. Sample indices and all candidate state restart at 0 for the next record, even when only one idle cycle separates the records.
- R7: While `rst_ni` is low, `deriv_valid_o`, `deriv_last_o` and `onset_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Sample strobe |
| last_i | input | 1 | Final sample of a record, qualified by valid_i |
| sample_i | input | SAMPLE_W | Signed pressure sample |
| thresh_i | input | SAMPLE_W+3 | Signed amplitude threshold, held stable during a record |
| deriv_valid_o | output | 1 | Derivative strobe |
| deriv_last_o | output | 1 | Final derivative of a record |
| deriv_o | output | SAMPLE_W+3 | Signed second derivative of the negated stream |
| onset_valid_o | output | 1 | Confirmed onset strobe |
| onset_idx_o | output | IDX_W | Record-relative sample index of the confirmed onset |

## Verification
The bench drives spike trains whose onsets lie exactly MIN_GAP and MIN_GAP+1 samples apart. A design that compared with "greater or equal" would report onsets for the first train, and one that compared strictly but with an off-by-one would miss them in the second. A further train places its spike exactly on the threshold, which catches a non-strict crossing test. Spikes on the first and the final sample exercise the one-sided end differences and the flush of the last derivative; a wrong end formula or a lost flush shows up as a value or count miscompare. Two records separated by a single idle cycle would expose a stale pending candidate or an index that fails to restart, as a spurious onset or a shifted index. Full-scale alternating samples expose a datapath that is too narrow.

// File: rtl/pod_pkg.sv
`timescale 1ns/1ps
package pod_pkg;
  // Fill state of a gradient stage within a record
  typedef enum logic [1:0] {
    FILL_EMPTY,
    FILL_ONE,
    FILL_RUN
  } fill_e;
endpackage

// File: rtl/pod_grad_stage.sv
`timescale 1ns/1ps
module pod_grad_stage
  import pod_pkg::*;
#(
  parameter int DW = 19
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 last_i,
  input  logic signed [DW-1:0] data_i,
  output logic                 valid_o,
  output logic                 last_o,
  output logic signed [DW-1:0] data_o
);

  fill_e              fill_q;
  logic               flush_q;
  logic signed [DW-1:0] prev_q, prev2_q;
  logic signed [DW-1:0] fwd_d, ctr_d, tail_d;

  assign fwd_d  = data_i - prev_q;
  assign ctr_d  = (data_i - prev2_q) >>> 1;
  assign tail_d = prev_q - prev2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q  <= FILL_EMPTY;
      flush_q <= 1'b0;
      prev_q  <= '0;
      prev2_q <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      if (valid_i) begin
        prev2_q <= prev_q;
        prev_q  <= data_i;
        unique case (fill_q)
          FILL_EMPTY: fill_q <= FILL_ONE;
          FILL_ONE: begin
            valid_o <= 1'b1;
            data_o  <= fwd_d;
            fill_q  <= FILL_RUN;
          end
          FILL_RUN: begin
            valid_o <= 1'b1;
            data_o  <= ctr_d;
          end
          default: fill_q <= FILL_EMPTY;
        endcase
        if (last_i) begin
          flush_q <= 1'b1;
          fill_q  <= FILL_EMPTY;
        end
      end else if (flush_q) begin
        // trailing one-sided point of the record
        valid_o <= 1'b1;
        last_o  <= 1'b1;
        data_o  <= tail_d;
        flush_q <= 1'b0;
      end
    end
  end

  // R3
  idle_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_i) |=> !valid_i);

  // R3
  last_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

endmodule

// File: rtl/pod_onset_track.sv
`timescale 1ns/1ps
module pod_onset_track #(
  parameter int F_W     = 19,
  parameter int IDX_W   = 16,
  parameter int MIN_GAP = 50
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic                  last_i,
  input  logic signed [F_W-1:0] f_i,
  input  logic signed [F_W-1:0] thresh_i,
  output logic                  onset_valid_o,
  output logic [IDX_W-1:0]      onset_idx_o
);

  localparam logic [IDX_W-1:0] GAP_LIM = IDX_W'(MIN_GAP);

  logic [IDX_W-1:0]      idx_q, pend_idx_q;
  logic signed [F_W-1:0] prev_f_q;
  logic                  have_prev_q, pend_q;
  logic                  hit, confirm;
  logic [IDX_W-1:0]      cand_idx, gap;

  assign hit      = valid_i && have_prev_q && (prev_f_q < thresh_i) && (f_i > thresh_i);
  assign cand_idx = idx_q - 1'b1;
  assign gap      = cand_idx - pend_idx_q;
  assign confirm  = hit && pend_q && (gap > GAP_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q         <= '0;
      pend_idx_q    <= '0;
      prev_f_q      <= '0;
      have_prev_q   <= 1'b0;
      pend_q        <= 1'b0;
      onset_valid_o <= 1'b0;
      onset_idx_o   <= '0;
    end else begin
      onset_valid_o <= 1'b0;
      if (valid_i) begin
        prev_f_q    <= f_i;
        have_prev_q <= 1'b1;
        idx_q       <= idx_q + 1'b1;
        if (hit) begin
          pend_q     <= 1'b1;
          pend_idx_q <= cand_idx;
        end
        if (confirm) begin
          onset_valid_o <= 1'b1;
          onset_idx_o   <= pend_idx_q;
        end
        if (last_i) begin
          idx_q       <= '0;
          have_prev_q <= 1'b0;
          pend_q      <= 1'b0;
        end
      end
    end
  end

  // R5
  onset_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    onset_valid_o |-> ((pend_idx_q - onset_idx_o) > GAP_LIM));

  // R6
  record_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && last_i) |-> (!pend_q && !have_prev_q && idx_q == '0));

endmodule

// File: rtl/pulse_onset_detector.sv
`timescale 1ns/1ps
module pulse_onset_detector #(
  parameter int SAMPLE_W = 16,
  parameter int IDX_W    = 16,
  parameter int MIN_GAP  = 50
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic                      last_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic signed [SAMPLE_W+2:0] thresh_i,
  output logic                      deriv_valid_o,
  output logic                      deriv_last_o,
  output logic signed [SAMPLE_W+2:0] deriv_o,
  output logic                      onset_valid_o,
  output logic [IDX_W-1:0]          onset_idx_o
);

  localparam int NUM_GRAD = 2;
  localparam int F_W      = SAMPLE_W + 1 + NUM_GRAD;  // negation bit + one per stage

  logic                  stg_valid [0:NUM_GRAD];
  logic                  stg_last  [0:NUM_GRAD];
  logic signed [F_W-1:0] stg_data  [0:NUM_GRAD];
  logic signed [F_W-1:0] samp_ext;

  assign samp_ext    = F_W'(sample_i);
  assign stg_valid[0] = valid_i;
  assign stg_last[0]  = last_i;
  assign stg_data[0]  = -samp_ext;

  for (genvar s = 0; s < NUM_GRAD; s++) begin : g_grad
    pod_grad_stage #(.DW(F_W)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(stg_valid[s]),
      .last_i (stg_last[s]),
      .data_i (stg_data[s]),
      .valid_o(stg_valid[s+1]),
      .last_o (stg_last[s+1]),
      .data_o (stg_data[s+1])
    );
  end

  assign deriv_valid_o = stg_valid[NUM_GRAD];
  assign deriv_last_o  = stg_last[NUM_GRAD];
  assign deriv_o       = stg_data[NUM_GRAD];

  pod_onset_track #(
    .F_W    (F_W),
    .IDX_W  (IDX_W),
    .MIN_GAP(MIN_GAP)
  ) u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (stg_valid[NUM_GRAD]),
    .last_i       (stg_last[NUM_GRAD]),
    .f_i          (stg_data[NUM_GRAD]),
    .thresh_i     (thresh_i),
    .onset_valid_o(onset_valid_o),
    .onset_idx_o  (onset_idx_o)
  );

  // R5
  onset_after_deriv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    onset_valid_o |-> $past(deriv_valid_o));

endmodule

// File: tb/pulse_onset_detector_tb.sv
`timescale 1ns/1ps
module pulse_onset_detector_tb;

  typedef int iq_t[$];

  localparam int PER_NS = 20;
  localparam int GAP    = 50;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               valid = 1'b0;
  logic               last = 1'b0;
  logic signed [15:0] sample = '0;
  logic signed [18:0] thresh = '0;
  logic               deriv_valid, deriv_last, onset_valid;
  logic signed [18:0] deriv;
  logic [15:0]        onset_idx;

  pulse_onset_detector u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .last_i(last),
    .sample_i(sample), .thresh_i(thresh),
    .deriv_valid_o(deriv_valid), .deriv_last_o(deriv_last), .deriv_o(deriv),
    .onset_valid_o(onset_valid), .onset_idx_o(onset_idx)
  );

  always #(PER_NS/2) clk = ~clk;

  int  checks = 0, fails = 0, cycles = 0;
  int  exp_f[$];
  bit  exp_l[$];
  int  cur_thr = 0;
  int  rec_onsets = 0;
  bit  lat_on = 0;
  time t_last = 0;
  bit  done = 0;
  // behavioural reference detector state
  int  r_idx = 0, r_prev = 0, r_pidx = 0;
  bit  r_have = 0, r_pend = 0;
  bit  on_exp = 0;
  int  on_idx_exp = 0;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      // R7
      checks++;
      if (deriv_valid || deriv_last || onset_valid) begin
        fails++;
        $display("FAIL R7 reset outputs got %0b%0b%0b expected 000", deriv_valid, deriv_last, onset_valid);
      end
    end else begin
      cycles++;
      // R5 per-cycle onset comparison
      checks++;
      if (onset_valid !== on_exp) begin
        fails++;
        $display("FAIL R5 onset_valid got %0b expected %0b", onset_valid, on_exp);
      end else if (on_exp && int'(onset_idx) != on_idx_exp) begin
        fails++;
        $display("FAIL R5 onset_idx got %0d expected %0d", onset_idx, on_idx_exp);
      end
      if (onset_valid) rec_onsets++;
      on_exp = 0;
      if (deriv_valid) begin
        checks++;
        if (exp_f.size() == 0) begin
          fails++;
          $display("FAIL R3 extra derivative got %0d expected none", deriv);
        end else begin
          int ef; bit el;
          ef = exp_f.pop_front();
          el = exp_l.pop_front();
          if (int'(deriv) != ef || deriv_last != el) begin
            fails++;
            $display("FAIL R1 R2 deriv got %0d/%0b expected %0d/%0b", deriv, deriv_last, ef, el);
          end
          // R4 strict crossing, R5 spacing rule in the reference
          if (r_have && r_prev < cur_thr && ef > cur_thr) begin
            if (r_pend && (r_idx - 1 - r_pidx) > GAP) begin
              on_exp = 1;
              on_idx_exp = r_pidx;
            end
            r_pend = 1;
            r_pidx = r_idx - 1;
          end
          r_prev = ef; r_have = 1; r_idx++;
          if (el) begin
            r_idx = 0; r_have = 0; r_pend = 0;  // R6
            if (lat_on) begin
              checks++;
              if ($time - t_last != 4 * PER_NS) begin
                fails++;
                $display("FAIL R3 last-derivative delay got %0t expected %0t", $time - t_last, 4 * PER_NS);
              end
              lat_on = 0;
            end
          end
        end
      end
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog got %0d cycles expected completion", cycles);
        finish_run();
      end
    end
  end

  function automatic iq_t grad(iq_t a);
    iq_t g;
    int  n = a.size();
    g.push_back(a[1] - a[0]);
    for (int i = 1; i < n - 1; i++) g.push_back((a[i+1] - a[i-1]) >>> 1);
    g.push_back(a[n-1] - a[n-2]);
    return g;
  endfunction

  function automatic iq_t spikes(int n, int amp, iq_t pos);
    iq_t x;
    for (int i = 0; i < n; i++) x.push_back(0);
    foreach (pos[k]) x[pos[k]] = amp;
    return x;
  endfunction

  task automatic run_rec(iq_t x, int thr, int exp_on, string tag, bit lat, int idle);
    iq_t p, f;
    foreach (x[i]) p.push_back(-x[i]);   // R1
    f = grad(grad(p));                   // R2
    foreach (f[i]) begin
      exp_f.push_back(f[i]);
      exp_l.push_back(i == f.size() - 1);
    end
    cur_thr = thr;
    thresh = 19'(thr);
    rec_onsets = 0;
    lat_on = lat;
    foreach (x[i]) begin
      @(negedge clk);
      valid = 1'b1;
      sample = 16'(x[i]);
      last = (i == x.size() - 1);
      if (last) t_last = $time;
    end
    @(negedge clk);
    valid = 1'b0;
    last = 1'b0;
    repeat (idle - 1) @(negedge clk);
    if (exp_on >= 0) begin
      checks++;
      if (rec_onsets != exp_on) begin
        fails++;
        $display("FAIL %s onset count got %0d expected %0d", tag, rec_onsets, exp_on);
      end
    end
  endtask

  initial begin
    iq_t x;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // spacing 80: two of three candidates confirmed (R5, R6)
    run_rec(spikes(260, 1000, '{20, 100, 180}), 100, 2, "R6", 1, 10);
    // spacing exactly MIN_GAP: nothing confirmed (R5)
    run_rec(spikes(160, 1000, '{20, 70, 120}), 100, 0, "R5", 0, 10);
    // spacing MIN_GAP+1: confirmed (R5)
    run_rec(spikes(160, 1000, '{20, 71, 122}), 100, 2, "R5", 0, 10);
    // derivative peak equal to threshold: no crossing (R4)
    run_rec(spikes(200, 1000, '{20, 100, 180}), 500, 0, "R4", 0, 10);
    // negative spikes incl. first and final sample (R1, R2, R3)
    run_rec(spikes(180, -1000, '{1, 60, 120, 179}), 100, 3, "R1", 1, 10);
    // back-to-back records with a single idle cycle (R6)
    run_rec(spikes(130, 1000, '{20, 100}), 100, 1, "R6", 0, 1);
    run_rec(spikes(130, 1000, '{20, 100}), 100, 1, "R6", 1, 10);
    // full-scale alternating samples (R2 width)
    x.delete();
    for (int i = 0; i < 40; i++) x.push_back((i % 2) ? -32768 : 32767);
    run_rec(x, 0, -1, "R2", 1, 10);
    // random noise record
    x.delete();
    for (int i = 0; i < 300; i++) x.push_back(int'($urandom_range(6000)) - 3000);
    run_rec(x, 2000, -1, "R5", 0, 10);
    // shortest record (R3)
    run_rec('{5, -7}, 0, 0, "R3", 1, 10);
    checks++;
    if (exp_f.size() != 0) begin
      fails++;
      $display("FAIL R3 derivative count got %0d missing expected 0", exp_f.size());
    end
    finish_run();
  end

endmodule